// File: doc/BRIEF.md
# Time-Slot Interchange Cross-Connect

This block is a single-stage byte switch for frames carried in parallel. Each of its input and output lanes carries twelve byte-interleaved STS-1 timeslots, one byte per lane per clock. For every output lane and timeslot, a connection entry names the input lane and input timeslot that supply the byte. An entry can instead force the slot to an all-ones alarm fill (AIS) or to an all-zeros unequipped fill. Each input lane writes one row of twelve bytes into one half of a ping-pong store while the other half, holding the row before it, is read through the connection map. Because of this, any input timeslot can reach any output position, and one source can feed any number of outputs.

Software works through a small register port. Writes go to a shadow copy of the map. Reads return the active copy. Writing the control word requests a commit, and the shadow replaces the active map at the next output frame boundary. The change is hitless: every byte of an output frame is taken through one map. A frame is a fixed number of twelve-byte rows and begins with a one-cycle input sync pulse. The output sync marks the first byte of the matching output frame.

Top module: `tsi_xconnect`

## Requirements
- R1: Output byte for lane L, slot s of output row r of a frame equals the input byte of lane E.lane, slot E.slot of input row r of the same frame, where E is entry L*12+s with mode 0. Map word: bits [3:0] source slot, [5:4] source lane, [7:6] mode.
- R2: One input timeslot can feed any number of output slots at once, up to all 48.
- R3: Every member of a concatenated group (three or twelve slots) comes from the same input row, so a group mapped slot by slot arrives intact and in order in one output row.
- R4: Shadow writes (addresses 0..47, entry = out_lane*12 + out_slot) change neither the output nor the active map until a commit has taken effect.
- R5: Writing bit 0 = 1 to address 63 requests a commit. The status bit (bit 0 of a read of address 63) is set from the next cycle until the swap. The swap happens at the next output frame boundary. A request made in the boundary cycle itself applies at the following boundary.
- R6: Mode 1 fills the output slot with 8'hFF. Modes 2 and 3 fill it with 8'h00.
- R7: A mode 0 entry whose source slot is 12..15 yields 8'h00.
- R8: A read returns the active entry in bits [7:0] one cycle after the address is presented. Address 63 returns the status bit, and addresses 48..62 read as zero and ignore writes.
- R9: The output sync is high for exactly one cycle, 13 cycles after the input sync. That is the cycle in which the byte of output row 0, slot 0 appears.
- R10: After reset, output data, output sync and read data are zero, the status bit is clear, and both map copies hold the identity connection (entry i = lane i/12, slot i%12, mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sync | input | 1 | High with the first byte of an input frame |
| in_data | input | 32 | One byte per input lane, lane 0 in bits [7:0] |
| out_sync | output | 1 | High with the first byte of an output frame |
| out_data | output | 32 | One byte per output lane, lane 0 in bits [7:0] |
| cpu_addr | input | 6 | Register address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 10 | Register write data |
| cpu_rdata | output | 10 | Registered read data for the previous cycle's address |

## Verification
The hardest case to reach from the ports is a commit request that lands in the exact cycle of the output frame boundary. Only then does the rule that the swap is deferred one full frame come into play. The bench drives all stimulus from a single process that knows the frame position of every cycle. It places the control write in that cycle on purpose, and also scatters random writes, commits and reads over many frames so that commits fall at other positions too. Every output byte is then compared with a frame model that tracks the shadow map, the active map and the pending request.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int LANES     = 4;
    localparam int SLOTS     = 12;
    localparam int BYTE_W    = 8;
    localparam int CPU_AW    = 6;
    localparam int CPU_DW    = 10;

    localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int SLOT_W    = $clog2(SLOTS + 1);
    localparam int ENTRIES   = LANES * SLOTS;

    localparam logic [CPU_AW-1:0] CTRL_ADDR = '1;

    typedef enum logic [1:0] {
        M_LINK  = 2'd0,
        M_AIS   = 2'd1,
        M_UNEQ  = 2'd2,
        M_UNEQ2 = 2'd3
    } tmode_e;

    typedef struct packed {
        tmode_e              mode;
        logic [LANE_W-1:0]   lane;
        logic [SLOT_W-1:0]   slot;
    } xent_t;

    localparam int ENT_W = $bits(xent_t);

    typedef logic [LANES-1:0][SLOTS-1:0][BYTE_W-1:0] row_bytes_t;
    typedef logic [LANES-1:0][BYTE_W-1:0]            lane_bytes_t;

    function automatic xent_t ident_ent(input int idx);
        xent_t e;
        e.mode = M_LINK;
        e.lane = LANE_W'(idx / SLOTS);
        e.slot = SLOT_W'(idx % SLOTS);
        return e;
    endfunction

    function automatic logic [BYTE_W-1:0] fill_byte(input tmode_e m);
        return (m == M_AIS) ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
    endfunction

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
    import tsi_pkg::*;
#(
    parameter int ROWS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_sync,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              wr_bank,
    output logic              boundary
);
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

    logic [SLOT_W-1:0] slot_q;
    logic [ROW_W-1:0]  row_q;
    logic              bank_q;
    logic [ROW_W-1:0]  cur_row;
    logic [ROW_W-1:0]  rd_row;

    always_comb begin
        cur_slot = in_sync ? '0 : slot_q;
        cur_row  = in_sync ? '0 : row_q;
        rd_row   = (cur_row == '0) ? ROW_W'(ROWS - 1) : cur_row - 1'b1;
        boundary = (cur_slot == '0) && (rd_row == '0);
    end

    assign wr_bank = bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            row_q  <= '0;
            bank_q <= 1'b0;
        end else if (int'(cur_slot) == SLOTS - 1) begin
            slot_q <= '0;
            row_q  <= (int'(cur_row) == ROWS - 1) ? '0 : cur_row + 1'b1;
            bank_q <= ~bank_q;
        end else begin
            slot_q <= cur_slot + 1'b1;
            row_q  <= cur_row;
        end
    end
endmodule

// File: rtl/tsi_store.sv
module tsi_store
    import tsi_pkg::*;
(
    input  logic              clk,
    input  lane_bytes_t       in_bytes,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_bank,
    output row_bytes_t        prev_row
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BYTE_W-1:0] mem_a [SLOTS];
        logic [BYTE_W-1:0] mem_b [SLOTS];

        always_ff @(posedge clk) begin
            if (int'(wr_slot) < SLOTS) begin
                if (wr_bank) mem_b[wr_slot] <= in_bytes[l];
                else         mem_a[wr_slot] <= in_bytes[l];
            end
        end

        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            assign prev_row[l][s] = wr_bank ? mem_a[s] : mem_b[s];
        end
    end
endmodule

// File: rtl/tsi_map.sv
module tsi_map
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [CPU_DW-1:0] cpu_wdata,
    input  logic              boundary,
    output xent_t             ent_use [ENTRIES],
    output logic [ENTRIES*ENT_W-1:0] active_flat,
    output logic [CPU_DW-1:0] cpu_rdata,
    output logic              pending,
    output logic              commit
);
    xent_t shadow [ENTRIES];
    xent_t active [ENTRIES];
    logic  swap;
    logic  in_map;

    assign in_map = int'(cpu_addr) < ENTRIES;
    assign commit = cpu_wr && (cpu_addr == CTRL_ADDR) && cpu_wdata[0];
    assign swap   = boundary && pending;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        assign ent_use[i] = swap ? shadow[i] : active[i];
        assign active_flat[i*ENT_W +: ENT_W] = active[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[i] <= ident_ent(i);
                active[i] <= ident_ent(i);
            end else begin
                if (cpu_wr && int'(cpu_addr) == i)
                    shadow[i] <= xent_t'(cpu_wdata[ENT_W-1:0]);
                if (swap)
                    active[i] <= shadow[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            if (swap)   pending <= 1'b0;
            if (commit) pending <= 1'b1;
            if (in_map)
                cpu_rdata <= CPU_DW'(active[cpu_addr]);
            else if (cpu_addr == CTRL_ADDR)
                cpu_rdata <= CPU_DW'(pending);
            else
                cpu_rdata <= '0;
        end
    end
endmodule

// File: rtl/tsi_outsel.sv
module tsi_outsel
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  row_bytes_t        prev_row,
    input  xent_t             ent,
    output logic [BYTE_W-1:0] out_byte
);
    logic [BYTE_W-1:0] picked;

    always_comb begin
        picked = '0;
        if (ent.mode == M_LINK) begin
            for (int s = 0; s < SLOTS; s++)
                if (int'(ent.slot) == s) picked = prev_row[ent.lane][s];
        end else begin
            picked = fill_byte(ent.mode);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_byte <= '0;
        else     out_byte <= picked;
    end
endmodule

// File: rtl/tsi_xconnect.sv
module tsi_xconnect
    import tsi_pkg::*;
#(
    parameter int ROWS = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_sync,
    input  logic [LANES*BYTE_W-1:0] in_data,
    output logic                    out_sync,
    output logic [LANES*BYTE_W-1:0] out_data,
    input  logic [CPU_AW-1:0]       cpu_addr,
    input  logic                    cpu_wr,
    input  logic [CPU_DW-1:0]       cpu_wdata,
    output logic [CPU_DW-1:0]       cpu_rdata
);
    logic [SLOT_W-1:0]          cur_slot;
    logic                       wr_bank;
    logic                       tm_boundary;
    row_bytes_t                 prev_row;
    lane_bytes_t                in_bytes;
    lane_bytes_t                out_bytes;
    xent_t                      ent_use [ENTRIES];
    xent_t                      lane_ent [LANES];
    logic [ENTRIES*ENT_W-1:0]   active_flat;
    logic                       map_pending;
    logic                       map_commit;
    tmode_e                     sel_mode0;

    assign in_bytes = in_data;
    assign out_data = out_bytes;

    tsi_timing #(.ROWS(ROWS)) u_timing (
        .clk(clk), .rst(rst), .in_sync(in_sync),
        .cur_slot(cur_slot), .wr_bank(wr_bank), .boundary(tm_boundary)
    );

    tsi_store u_store (
        .clk(clk), .in_bytes(in_bytes), .wr_slot(cur_slot),
        .wr_bank(wr_bank), .prev_row(prev_row)
    );

    tsi_map u_map (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .boundary(tm_boundary), .ent_use(ent_use),
        .active_flat(active_flat), .cpu_rdata(cpu_rdata),
        .pending(map_pending), .commit(map_commit)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_out
        always_comb begin
            lane_ent[l] = ent_use[l*SLOTS];
            for (int s = 0; s < SLOTS; s++)
                if (int'(cur_slot) == s) lane_ent[l] = ent_use[l*SLOTS + s];
        end

        tsi_outsel u_sel (
            .clk(clk), .rst(rst), .prev_row(prev_row),
            .ent(lane_ent[l]), .out_byte(out_bytes[l])
        );
    end

    assign sel_mode0 = lane_ent[0].mode;

    always_ff @(posedge clk) begin
        if (rst) out_sync <= 1'b0;
        else     out_sync <= tm_boundary;
    end
endmodule

// File: rtl/tsi_xconnect_chk.sv
module tsi_xconnect_chk
    import tsi_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     out_sync,
    input logic                     pending,
    input logic                     commit,
    input logic                     boundary,
    input logic [ENTRIES*ENT_W-1:0] active_flat,
    input tmode_e                   lane0_mode,
    input logic [BYTE_W-1:0]        out_lane0
);
    p_sync_single_r9: assert property (@(posedge clk) disable iff (rst)
        out_sync |=> !out_sync);

    p_commit_sets_r5: assert property (@(posedge clk) disable iff (rst)
        commit |=> pending);

    p_swap_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (boundary && pending && !commit) |=> !pending);

    p_pending_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!commit && !boundary) |=> $stable(pending));

    p_active_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(active_flat));

    p_ais_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (lane0_mode == M_AIS) |=> (out_lane0 == {BYTE_W{1'b1}}));

    p_uneq_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (lane0_mode == M_UNEQ || lane0_mode == M_UNEQ2) |=> (out_lane0 == '0));
endmodule

bind tsi_xconnect tsi_xconnect_chk u_chk (
    .clk(clk), .rst(rst), .out_sync(out_sync), .pending(map_pending),
    .commit(map_commit), .boundary(tm_boundary), .active_flat(active_flat),
    .lane0_mode(sel_mode0), .out_lane0(out_data[7:0])
);

// File: tb/sim_tsi_xconnect.sv
`timescale 1ns/1ps
module sim_tsi_xconnect;
    localparam int NL = 4, NS = 12, NR = 3, FR = NS * NR, NE = NL * NS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_sync = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_sync;
    logic [31:0] out_data;
    logic [5:0]  cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [9:0]  cpu_wdata = '0;
    logic [9:0]  cpu_rdata;

    always #2.5 clk = ~clk;

    tsi_xconnect u0 (
        .clk(clk), .rst(rst), .in_sync(in_sync), .in_data(in_data),
        .out_sync(out_sync), .out_data(out_data), .cpu_addr(cpu_addr),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    int n_run = 0, n_fail = 0;
    int fr = 0, p = 0;
    bit started = 0;
    int salt [8];
    logic [7:0] b_sh [NE];
    logic [7:0] b_act [NE];
    bit b_pend = 0;
    string cur_tag = "R9";

    // requested CPU action for the next drive, and the one presented
    bit c_wr = 0, c_chk = 0;  logic [5:0] c_addr = '0; logic [9:0] c_wd = '0; string c_tag = "R8";
    bit q_wr = 0, q_chk = 0;  logic [5:0] q_addr = '0; logic [9:0] q_wd = '0; string q_tag = "R8";

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (frame %0d pos %0d)", tag, act, exp, fr, p);
        end
    endtask

    function automatic logic [7:0] gb(int f, int r, int l, int s);
        return 8'((f * 97 + r * 41 + l * 59 + s * 13 + salt[f % 8]) & 255);
    endfunction

    function automatic logic [7:0] mk(int m, int l, int s);
        return {2'(m), 2'(l), 4'(s)};
    endfunction

    function automatic logic [7:0] exp_byte(logic [7:0] e, int f, int r);
        int m = e[7:6];
        if (m == 1) return 8'hFF;
        if (m >= 2) return 8'h00;
        if (e[3:0] >= NS) return 8'h00;
        return gb(f, r, e[5:4], e[3:0]);
    endfunction

    task automatic model();
        logic [7:0] use_m [NE];
        bit bnd = (p == NS);
        int rf = (p >= NS) ? fr : fr - 1;
        int rr = (p >= NS) ? p / NS - 1 : NR - 1;
        for (int i = 0; i < NE; i++) use_m[i] = (bnd && b_pend) ? b_sh[i] : b_act[i];
        if (q_chk) begin
            int ex = (q_addr < NE) ? int'(b_act[q_addr]) : (q_addr == 63) ? int'(b_pend) : 0;
            chk(q_tag, cpu_rdata, ex);
        end
        chk("R9", out_sync, bnd);
        if (rf >= 0)
            for (int l = 0; l < NL; l++)
                chk(cur_tag, out_data[l*8 +: 8], exp_byte(use_m[l*NS + p % NS], rf, rr));
        if (bnd && b_pend) begin
            for (int i = 0; i < NE; i++) b_act[i] = b_sh[i];
            b_pend = 0;
        end
        if (q_wr && q_addr == 63 && q_wd[0]) b_pend = 1;
        if (q_wr && q_addr < NE) b_sh[q_addr] = q_wd[7:0];
    endtask

    task automatic drive();
        in_sync = (p == 0);
        for (int l = 0; l < NL; l++) in_data[l*8 +: 8] = gb(fr, p / NS, l, p % NS);
        q_wr = c_wr; q_chk = c_chk; q_addr = c_addr; q_wd = c_wd; q_tag = c_tag;
        cpu_wr = c_wr; cpu_addr = c_addr; cpu_wdata = c_wd;
    endtask

    task automatic step();
        @(negedge clk);
        if (started) begin
            model();
            if (p == FR - 1) begin p = 0; fr++; salt[fr % 8] = int'($urandom); end
            else p++;
        end
        started = 1;
        drive();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(int a, int d);
        c_wr = 1; c_addr = 6'(a); c_wd = 10'(d); step(); c_wr = 0;
    endtask

    task automatic rd(int a, string tag);
        c_chk = 1; c_addr = 6'(a); c_tag = tag; step(); c_chk = 0; step();
    endtask

    task automatic commit_mid();
        while (p != 20) step();
        wr(63, 1);
    endtask

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < 8; i++) salt[i] = int'($urandom);
        for (int i = 0; i < NE; i++) begin b_sh[i] = mk(0, i / NS, i % NS); b_act[i] = b_sh[i]; end
        repeat (4) @(negedge clk);
        // R10: reset state
        chk("R10", out_data, 0);
        chk("R10", out_sync, 0);
        chk("R10", cpu_rdata, 0);
        @(negedge clk);
        rst = 0;
        drive();
        started = 1;
        rd(17, "R10");
        rd(63, "R10");
        cur_tag = "R9";
        run(2 * FR);

        // R4: shadow writes alone do not reach the output
        cur_tag = "R4";
        for (int i = 0; i < NE; i++) wr(i, mk(0, $urandom_range(0, 3), $urandom_range(0, 11)));
        run(FR);
        rd(5, "R8");

        // R1 / R5: commit mid frame
        commit_mid();
        rd(63, "R5");
        cur_tag = "R1";
        run(2 * FR);
        rd(63, "R5");
        rd(5, "R8");

        // R2: full broadcast from lane 3 slot 7
        for (int i = 0; i < NE; i++) wr(i, mk(0, 3, 7));
        commit_mid();
        cur_tag = "R2";
        run(2 * FR);

        // R3: a 3c group and a 12c group
        for (int k = 0; k < 3; k++) wr(k, mk(0, 2, 6 + k));
        for (int s = 0; s < NS; s++) wr(NS + s, mk(0, 3, s));
        commit_mid();
        cur_tag = "R3";
        run(2 * FR);

        // R6: mixed fill modes
        for (int i = 0; i < NE; i++) wr(i, mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 11)));
        wr(0, mk(1, 0, 0)); wr(1, mk(2, 0, 0)); wr(2, mk(3, 0, 0));
        commit_mid();
        cur_tag = "R6";
        run(2 * FR);

        // R7: source slot out of range
        for (int i = 0; i < NE; i++) wr(i, mk(0, $urandom_range(0, 3), $urandom_range(0, 15)));
        wr(3, mk(0, 1, 12)); wr(4, mk(0, 2, 15));
        commit_mid();
        cur_tag = "R7";
        run(2 * FR);

        // R5: commit presented in the boundary cycle itself
        for (int i = 0; i < NE; i++) wr(i, mk(0, 0, 0));
        while (p != NS - 1) step();
        cur_tag = "R5";
        wr(63, 1);
        rd(63, "R5");
        run(FR);
        rd(63, "R5");
        run(FR);

        // R8: unmapped addresses
        wr(50, 8'h5A);
        rd(50, "R8");
        rd(62, "R8");

        // random mix of writes, commits and reads
        cur_tag = "R1";
        for (int i = 0; i < 20 * FR; i++) begin
            int r = $urandom_range(0, 15);
            if (r == 0) wr(63, 1);
            else if (r < 3) wr($urandom_range(0, 63), $urandom_range(0, 1023));
            else if (r == 3) rd($urandom_range(0, 63), "R8");
            else step();
        end
        run(2);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule